// File: doc/BRIEF.md
# I2C Target Controller with Byte Ring Buffers

This block is a target (slave) on a two-wire I2C bus. It runs on a fast system clock and treats the bus lines as ordinary inputs. Each line passes through a synchronizer before the block uses it. The block drives the lines only through open-drain pull-down enables. It recognizes START, repeated START and STOP conditions. It compares the address byte against a 7-bit own address and also accepts the general-call address. It acknowledges the bytes it accepts.

Bytes that the bus controller writes are stored in a receive ring buffer. Bytes that the controller reads are taken from a transmit ring buffer. The local logic fills the transmit ring through a push port and drains the receive ring through a pop port. Empty flags, a transmit full flag and a receive occupancy count are available. At the START and at the end of every byte or acknowledge phase, the block holds SCL low for a fixed number of system clocks while it prepares the next phase.

Top module: `i2c_tgt_ring`

## Requirements
- R1: After rst_ni is asserted, both open-drain enables are released (0), both rings are empty, tx_full_o is 0 and rx_count_o is 0.
- R2: An address byte is accepted when its upper seven bits equal own_addr_i. The target then drives the ninth bit low (ACK). Byte bit 0 selects the direction: 0 means the controller writes, 1 means the controller reads.
- R3: The address byte 0x00 (general call) is accepted as a write and acknowledged.
- R4: When the address does not match, the ninth bit is left high (no ACK). Every following byte is ignored (not stored, not acknowledged) until the next START.
- R5: In a write transfer, each data byte is shifted in MSB first, stored in the receive ring and acknowledged. The bytes come out of rx_data_o in the order they arrived.
- R6: In a read transfer, bytes are popped from the transmit ring and sent MSB first, with SDA changing only while SCL is low. After the controller ACKs a byte, the target sends the next one.
- R7: A NACK from the controller after a transmitted byte ends the read. Bytes that were not sent remain in the transmit ring.
- R8: If the transmit ring is empty when a byte is due, the target releases SDA, so the controller reads 0xFF, and goes idle. The target never pops an empty ring.
- R9: A repeated START in the middle of a transfer sends the target back to address checking, and it may change direction.
- R10: A STOP in any state, including between a START and the first SCL fall, returns the target to idle. The target ignores any byte that is then clocked without a new START.
- R11: At the SCL fall after a START, after every byte and after every ACK phase that continues the transfer, scl_oe_o is asserted for STRETCH_CYC system clocks. The block pulls SCL only while SCL is already low.
- R12: A byte received while the receive ring is full is dropped but still acknowledged. The ring contents are unchanged.
- R13: Each ring holds at most DEPTH-1 bytes. The count reported is (head − tail) modulo DEPTH. tx_full_o is 1 at DEPTH-1 entries, and a push while full is ignored.
- R14: Apart from the reaction to START or STOP, sda_oe_o changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| own_addr_i | input | 7 | Own 7-bit bus address |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| tx_push_i | input | 1 | Write tx_data_i into the transmit ring |
| tx_data_i | input | 8 | Byte to transmit |
| tx_full_o | output | 1 | Transmit ring holds DEPTH-1 bytes |
| tx_empty_o | output | 1 | Transmit ring is empty |
| rx_pop_i | input | 1 | Remove the byte shown on rx_data_o |
| rx_data_o | output | 8 | Oldest received byte |
| rx_empty_o | output | 1 | Receive ring is empty |
| rx_count_o | output | $clog2(DEPTH) | Receive ring occupancy |

## Verification
Some properties are checked on every cycle. SDA changes only while SCL is low, and the stretch begins only on a low SCL. The target holds SDA low through the whole receive ACK bit and never pops an empty transmit ring. The rings keep their pointers on a push to a full ring or a pop from an empty one, and their level grows by one on an accepted push. Other behaviour can only be shown by bus scenarios run by the bench: address and general-call matching, ignoring bytes after a mismatch, MSB-first data order in both directions, the end of a read on NACK or on an empty transmit ring, a repeated START, a STOP just after a START, and dropping received bytes on overflow while still acknowledging them.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START_WAIT,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_TX_BYTE,
    ST_TX_ACK,
    ST_RX_BYTE,
    ST_RX_ACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_line_sync.sv
module i2c_tgt_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe_q, sda_pipe_q;
  logic scl_prev_q, sda_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_i};
      sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_i};
      scl_prev_q <= scl_o;
      sda_prev_q <= sda_o;
    end
  end

  assign scl_o      = scl_pipe_q[STAGES-1];
  assign sda_o      = sda_pipe_q[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_prev_q;
  assign scl_fall_o = ~scl_o & scl_prev_q;
  // SDA edges while SCL stays high
  assign start_o    = scl_o & scl_prev_q & sda_prev_q & ~sda_o;
  assign stop_o     = scl_o & scl_prev_q & ~sda_prev_q & sda_o;
endmodule

// File: rtl/i2c_tgt_ring_buf.sv
module i2c_tgt_ring_buf #(
  parameter  int unsigned DEPTH = 8,
  parameter  int unsigned WIDTH = 8,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [AW-1:0]    level_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    head_q, tail_q;
  logic             do_push, do_pop;

  assign empty_o = (head_q == tail_q);
  assign full_o  = ((head_q + AW'(1)) == tail_q);
  assign level_o = head_q - tail_q;
  assign rdata_o = mem_q[tail_q];
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (do_push) head_q <= head_q + AW'(1);
      if (do_pop)  tail_q <= tail_q + AW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[head_q] <= wdata_i;
  end

  // R12
  ring_full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> $stable(head_q));
  // R13
  ring_level_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o && !pop_i) |=> (level_o == $past(level_o) + AW'(1)));
  // R13
  ring_empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> $stable(tail_q));
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter  int unsigned STRETCH_CYC = 8,
  localparam int unsigned SW          = $clog2(STRETCH_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              tx_empty_i,
  input  logic              rx_full_i,
  output logic              tx_pop_o,
  output logic              rx_push_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o
);
  tgt_state_e        state_q, state_d;
  logic [BYTE_W-1:0] shreg_q, shreg_d;
  logic [3:0]        bitcnt_q, bitcnt_d;
  logic              rd_q, rd_d, nack_q, nack_d, sda_oe_q, sda_oe_d;
  logic              stretch_go;
  logic [SW-1:0]     stretch_q;
  logic              byte_done;

  assign byte_done = (bitcnt_q == 4'd8);

  always_comb begin
    state_d    = state_q;
    shreg_d    = shreg_q;
    bitcnt_d   = bitcnt_q;
    rd_d       = rd_q;
    nack_d     = nack_q;
    sda_oe_d   = sda_oe_q;
    stretch_go = 1'b0;
    tx_pop_o   = 1'b0;
    rx_push_o  = 1'b0;
    if (stop_i) begin
      state_d  = ST_IDLE;
      sda_oe_d = 1'b0;
    end else if (start_i) begin
      state_d  = ST_START_WAIT;
      sda_oe_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_START_WAIT: begin
          if (scl_fall_i) begin
            state_d    = ST_ADDR;
            bitcnt_d   = '0;
            stretch_go = 1'b1;
          end
        end
        ST_ADDR: begin
          if (scl_rise_i) begin
            shreg_d  = {shreg_q[BYTE_W-2:0], sda_s_i};
            bitcnt_d = bitcnt_q + 4'd1;
          end else if (scl_fall_i && byte_done) begin
            if (shreg_q == '0 || shreg_q[BYTE_W-1:1] == own_addr_i) begin
              rd_d       = shreg_q[0];
              sda_oe_d   = 1'b1;
              state_d    = ST_ADDR_ACK;
              stretch_go = 1'b1;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall_i) begin
            bitcnt_d = '0;
            if (!rd_q) begin
              sda_oe_d   = 1'b0;
              state_d    = ST_RX_BYTE;
              stretch_go = 1'b1;
            end else if (tx_empty_i) begin
              sda_oe_d = 1'b0;
              state_d  = ST_IDLE;
            end else begin
              tx_pop_o   = 1'b1;
              shreg_d    = tx_data_i;
              sda_oe_d   = ~tx_data_i[BYTE_W-1];
              state_d    = ST_TX_BYTE;
              stretch_go = 1'b1;
            end
          end
        end
        ST_TX_BYTE: begin
          if (scl_rise_i) begin
            bitcnt_d = bitcnt_q + 4'd1;
          end else if (scl_fall_i) begin
            if (byte_done) begin
              sda_oe_d   = 1'b0;
              state_d    = ST_TX_ACK;
              stretch_go = 1'b1;
            end else begin
              shreg_d  = {shreg_q[BYTE_W-2:0], 1'b0};
              sda_oe_d = ~shreg_q[BYTE_W-2];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise_i) begin
            nack_d = sda_s_i;
          end else if (scl_fall_i) begin
            bitcnt_d = '0;
            if (nack_q || tx_empty_i) begin
              sda_oe_d = 1'b0;
              state_d  = ST_IDLE;
            end else begin
              tx_pop_o   = 1'b1;
              shreg_d    = tx_data_i;
              sda_oe_d   = ~tx_data_i[BYTE_W-1];
              state_d    = ST_TX_BYTE;
              stretch_go = 1'b1;
            end
          end
        end
        ST_RX_BYTE: begin
          if (scl_rise_i) begin
            shreg_d  = {shreg_q[BYTE_W-2:0], sda_s_i};
            bitcnt_d = bitcnt_q + 4'd1;
          end else if (scl_fall_i && byte_done) begin
            rx_push_o  = ~rx_full_i;
            sda_oe_d   = 1'b1;
            state_d    = ST_RX_ACK;
            stretch_go = 1'b1;
          end
        end
        ST_RX_ACK: begin
          if (scl_fall_i) begin
            sda_oe_d   = 1'b0;
            bitcnt_d   = '0;
            state_d    = ST_RX_BYTE;
            stretch_go = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      shreg_q   <= '0;
      bitcnt_q  <= '0;
      rd_q      <= 1'b0;
      nack_q    <= 1'b0;
      sda_oe_q  <= 1'b0;
      stretch_q <= '0;
    end else begin
      state_q  <= state_d;
      shreg_q  <= shreg_d;
      bitcnt_q <= bitcnt_d;
      rd_q     <= rd_d;
      nack_q   <= nack_d;
      sda_oe_q <= sda_oe_d;
      if (stretch_go)          stretch_q <= SW'(STRETCH_CYC);
      else if (stretch_q != 0) stretch_q <= stretch_q - SW'(1);
    end
  end

  assign rx_data_o = shreg_q;
  assign sda_oe_o  = sda_oe_q;
  assign scl_oe_o  = (stretch_q != '0);

  // R14
  sda_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_oe_q) && !$past(start_i || stop_i)) |-> !scl_s_i);
  // R11
  stretch_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_oe_o) |-> !scl_s_i);
  // R5
  rx_ack_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RX_ACK) |-> sda_oe_o);
endmodule

// File: rtl/i2c_tgt_ring.sv
module i2c_tgt_ring
  import i2c_tgt_pkg::*;
#(
  parameter  int unsigned DEPTH       = 8,
  parameter  int unsigned STRETCH_CYC = 8,
  parameter  int unsigned SYNC_STAGES = 2,
  localparam int unsigned AW          = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic              tx_push_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  output logic              tx_full_o,
  output logic              tx_empty_o,
  input  logic              rx_pop_i,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_empty_o,
  output logic [AW-1:0]     rx_count_o
);
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              tx_pop, rx_push, rx_full;
  logic [BYTE_W-1:0] tx_head_byte, rx_wbyte;
  logic [AW-1:0]     tx_level;

  i2c_tgt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_tgt_engine #(.STRETCH_CYC(STRETCH_CYC)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .own_addr_i (own_addr_i),
    .scl_s_i    (scl_s),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .tx_data_i  (tx_head_byte),
    .tx_empty_i (tx_empty_o),
    .rx_full_i  (rx_full),
    .tx_pop_o   (tx_pop),
    .rx_push_o  (rx_push),
    .rx_data_o  (rx_wbyte),
    .scl_oe_o   (scl_oe_o),
    .sda_oe_o   (sda_oe_o)
  );

  i2c_tgt_ring_buf #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_tx_ring (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (tx_push_i),
    .wdata_i (tx_data_i),
    .pop_i   (tx_pop),
    .rdata_o (tx_head_byte),
    .full_o  (tx_full_o),
    .empty_o (tx_empty_o),
    .level_o (tx_level)
  );

  i2c_tgt_ring_buf #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_rx_ring (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_push),
    .wdata_i (rx_wbyte),
    .pop_i   (rx_pop_i),
    .rdata_o (rx_data_o),
    .full_o  (rx_full),
    .empty_o (rx_empty_o),
    .level_o (rx_count_o)
  );

  // R8
  tx_pop_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop |-> !tx_empty_o);
  // R13
  tx_full_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_full_o |-> (tx_level == AW'(DEPTH - 1)));
endmodule

// File: tb/i2c_tgt_ring_tb_top.sv
module i2c_tgt_ring_tb_top;
  localparam int DEPTH = 8;
  localparam int H     = 20;
  localparam logic [6:0] OWN = 7'h2A;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n;
  logic       m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic       scl_oe, sda_oe, scl_line, sda_line;
  logic       tx_push = 1'b0, rx_pop = 1'b0;
  logic [7:0] tx_data = '0, rx_data;
  logic       tx_full, tx_empty, rx_empty;
  logic [2:0] rx_count;

  assign scl_line = ~(m_scl_low | scl_oe);
  assign sda_line = ~(m_sda_low | sda_oe);

  i2c_tgt_ring #(.DEPTH(DEPTH), .STRETCH_CYC(8), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .own_addr_i(OWN),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .tx_push_i(tx_push), .tx_data_i(tx_data), .tx_full_o(tx_full), .tx_empty_o(tx_empty),
    .rx_pop_i(rx_pop), .rx_data_o(rx_data), .rx_empty_o(rx_empty), .rx_count_o(rx_count)
  );

  int n_chk = 0, n_fail = 0, n_sda_bad = 0;
  logic [7:0] exp_q[$];
  bit mon_en = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high;
    while (scl_line !== 1'b1) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda_low = 1'b1; hold(H);
    m_scl_low = 1'b1; hold(H);
  endtask

  task automatic bus_rstart;
    m_sda_low = 1'b0; hold(H);
    m_scl_low = 1'b0; wait_scl_high; hold(H);
    m_sda_low = 1'b1; hold(H);
    m_scl_low = 1'b1; hold(H);
  endtask

  task automatic bus_stop;
    m_sda_low = 1'b1; hold(H);
    m_scl_low = 1'b0; wait_scl_high; hold(H);
    m_sda_low = 1'b0; hold(H);
  endtask

  task automatic put_bit(bit b);
    m_sda_low = !b; hold(H);
    m_scl_low = 1'b0; wait_scl_high; hold(H);
    m_scl_low = 1'b1; hold(H);
  endtask

  task automatic get_bit(output bit b);
    m_sda_low = 1'b0; hold(H);
    m_scl_low = 1'b0; wait_scl_high; hold(H / 2);
    b = sda_line; hold(H / 2);
    m_scl_low = 1'b1; hold(H);
  endtask

  task automatic put_byte(logic [7:0] d, output bit ack);
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(ack);
  endtask

  task automatic get_byte(output logic [7:0] d, input bit ack);
    for (int i = 7; i >= 0; i--) begin
      bit b;
      get_bit(b);
      d[i] = b;
    end
    put_bit(ack);
  endtask

  task automatic push_tx(logic [7:0] d);
    @(negedge clk); tx_data = d; tx_push = 1'b1;
    @(negedge clk); tx_push = 1'b0;
  endtask

  task automatic drain(string req);
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, req, "bytes still expected", exp_q.size(), 0);
  endtask

  // scoreboard monitor: pops the receive ring and compares with expected queue
  initial begin
    forever begin
      @(negedge clk);
      rx_pop = 1'b0;
      if (mon_en && rst_n && !rx_empty) begin
        if (exp_q.size() == 0) chk(1'b0, "R5", "unexpected rx byte", rx_data, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rx_data == e, "R5", "rx byte", rx_data, e);
        end
        rx_pop = 1'b1;
      end
    end
  end

  // R14 observer: SDA enable must not move while SCL line is high
  initial begin
    logic prev_oe;
    prev_oe = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && sda_oe !== prev_oe && scl_line) n_sda_bad++;
      prev_oe = sda_oe;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] d;
    rst_n = 1'b0;
    hold(5);
    // R1
    chk(scl_oe == 0 && sda_oe == 0, "R1", "oe after reset", {scl_oe, sda_oe}, 0);
    chk(rx_empty && tx_empty && !tx_full, "R1", "flags after reset", {rx_empty, tx_empty, tx_full}, 3'b110);
    chk(rx_count == 0, "R1", "rx count after reset", rx_count, 0);
    rst_n = 1'b1;
    hold(5);
    mon_en = 1'b1;

    // R2 R5: write to own address
    exp_q.push_back(8'hC3); exp_q.push_back(8'h5A); exp_q.push_back(8'h01);
    bus_start;
    put_byte({OWN, 1'b0}, ack);
    chk(ack == 0, "R2", "address ack", ack, 0);
    put_byte(8'hC3, ack); chk(ack == 0, "R5", "data ack 0", ack, 0);
    put_byte(8'h5A, ack); chk(ack == 0, "R5", "data ack 1", ack, 0);
    put_byte(8'h01, ack); chk(ack == 0, "R5", "data ack 2", ack, 0);
    bus_stop;
    drain("R5");

    // R3: general call
    exp_q.push_back(8'h3E);
    bus_start;
    put_byte(8'h00, ack); chk(ack == 0, "R3", "general call ack", ack, 0);
    put_byte(8'h3E, ack); chk(ack == 0, "R3", "general call data ack", ack, 0);
    bus_stop;
    drain("R3");

    // R4: mismatch
    bus_start;
    put_byte({7'h15, 1'b0}, ack); chk(ack == 1, "R4", "mismatch address nack", ack, 1);
    put_byte(8'h77, ack); chk(ack == 1, "R4", "ignored data nack", ack, 1);
    bus_stop;
    hold(10);
    chk(rx_empty == 1, "R4", "nothing stored", rx_empty, 1);

    // R10: STOP right after START, then an unframed byte
    m_sda_low = 1'b1; hold(H);
    m_sda_low = 1'b0; hold(H);
    m_scl_low = 1'b1; hold(H);
    put_byte({OWN, 1'b0}, ack); chk(ack == 1, "R10", "byte without START ignored", ack, 1);
    bus_stop;
    chk(rx_empty == 1, "R10", "rx still empty", rx_empty, 1);

    // R11: stretch after START, after address byte, after ACK
    exp_q.push_back(8'h6D);
    m_sda_low = 1'b1; hold(H);
    m_scl_low = 1'b1; hold(5);
    chk(scl_oe == 1, "R11", "stretch after START", scl_oe, 1);
    hold(H);
    for (int i = 7; i >= 1; i--) put_bit(OWN[i-1]);
    m_sda_low = 1'b1; hold(H);
    m_scl_low = 1'b0; wait_scl_high; hold(H);
    m_scl_low = 1'b1; hold(5);
    chk(scl_oe == 1, "R11", "stretch after address byte", scl_oe, 1);
    chk(sda_oe == 1, "R2", "ack driven", sda_oe, 1);
    hold(H);
    m_sda_low = 1'b0; hold(H);
    m_scl_low = 1'b0; wait_scl_high; hold(H);
    m_scl_low = 1'b1; hold(5);
    chk(scl_oe == 1, "R11", "stretch after ACK", scl_oe, 1);
    hold(H);
    chk(scl_oe == 0, "R11", "stretch released", scl_oe, 0);
    put_byte(8'h6D, ack); chk(ack == 0, "R5", "data ack after stretch", ack, 0);
    bus_stop;
    drain("R11");

    // R6 R13: fill tx ring, read all
    for (int i = 0; i < DEPTH - 1; i++) push_tx(8'(8'h10 + i * 8'h23));
    chk(tx_full == 1, "R13", "tx full at DEPTH-1", tx_full, 1);
    push_tx(8'hEE);
    bus_start;
    put_byte({OWN, 1'b1}, ack); chk(ack == 0, "R2", "read address ack", ack, 0);
    for (int i = 0; i < DEPTH - 1; i++) begin
      get_byte(d, i == DEPTH - 2);
      chk(d == 8'(8'h10 + i * 8'h23), "R6", "read byte", d, 8'(8'h10 + i * 8'h23));
    end
    bus_stop;
    chk(tx_empty == 1, "R13", "push while full was ignored", tx_empty, 1);

    // R7: NACK keeps remaining bytes
    push_tx(8'hA1); push_tx(8'hB2);
    bus_start;
    put_byte({OWN, 1'b1}, ack);
    get_byte(d, 1'b1); chk(d == 8'hA1, "R7", "first read", d, 8'hA1);
    bus_stop;
    chk(tx_empty == 0, "R7", "byte remains after NACK", tx_empty, 0);
    bus_start;
    put_byte({OWN, 1'b1}, ack);
    get_byte(d, 1'b1); chk(d == 8'hB2, "R7", "remaining byte", d, 8'hB2);
    bus_stop;

    // R8: empty tx ring during read
    push_tx(8'h5C);
    bus_start;
    put_byte({OWN, 1'b1}, ack);
    get_byte(d, 1'b0); chk(d == 8'h5C, "R8", "last real byte", d, 8'h5C);
    get_byte(d, 1'b1); chk(d == 8'hFF, "R8", "released bus reads ones", d, 8'hFF);
    bus_stop;
    chk(sda_oe == 0, "R8", "sda released", sda_oe, 0);

    // R9: repeated START switches direction
    push_tx(8'h9E);
    exp_q.push_back(8'h42);
    bus_start;
    put_byte({OWN, 1'b0}, ack);
    put_byte(8'h42, ack); chk(ack == 0, "R9", "write before restart", ack, 0);
    bus_rstart;
    put_byte({OWN, 1'b1}, ack); chk(ack == 0, "R9", "address after restart", ack, 0);
    get_byte(d, 1'b1); chk(d == 8'h9E, "R9", "read after restart", d, 8'h9E);
    bus_stop;
    drain("R9");

    // R12 R13: overflow with monitor paused
    mon_en = 1'b0;
    bus_start;
    put_byte({OWN, 1'b0}, ack);
    for (int i = 0; i < 3; i++) put_byte(8'(8'h80 + i), ack);
    bus_stop;
    chk(rx_count == 3, "R13", "rx occupancy", rx_count, 3);
    bus_start;
    put_byte({OWN, 1'b0}, ack);
    for (int i = 3; i < DEPTH + 1; i++) begin
      put_byte(8'(8'h80 + i), ack);
      chk(ack == 0, "R12", "ack even when full", ack, 0);
    end
    bus_stop;
    chk(rx_count == DEPTH - 1, "R12", "rx occupancy capped", rx_count, DEPTH - 1);
    for (int i = 0; i < DEPTH - 1; i++) exp_q.push_back(8'(8'h80 + i));
    mon_en = 1'b1;
    drain("R12");
    hold(4);
    chk(rx_empty == 1 && rx_count == 0, "R13", "rx drained", rx_count, 0);

    // R14
    chk(n_sda_bad == 0, "R14", "sda enable moved while SCL high", n_sda_bad, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule